// File: doc/BRIEF.md
# Dual Compare-Match Timer

This block holds two independent up-counting timer channels behind a small register bus with single-cycle reads and writes. Every channel has a control word, a counter that software can load with any value, and a compare value. While a channel is enabled its counter advances, optionally slowed by a prescaler. When the counter steps off its compare value, the channel sets a pending bit in a status word that both channels share.

Software clears a pending bit by writing a 1 to that bit's position. A channel's interrupt line is its pending bit gated by its interrupt-enable bit. For one-shot use, software stops the channel, loads the counter (usually with 0), writes the desired delta of at least 2 ticks as the compare value, and enables the channel. The counter does not stop at the compare value. It keeps running and wraps, so software is expected to disable the channel once the event has been handled.

Top module: `twin_match_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `rdata` is 0.
- R2: Registers are decoded at byte offsets. Channel n control is at 0x00+4n, compare at 0x18+4n, counter at 0x48+4n, and the shared status word is at 0x60. A read of any other offset returns 0, and a write to any other offset changes no register.
- R3: Control bit 0 is the count enable. A written counter value is held while bit 0 is 0. Counting resumes from that value once bit 0 is 1. A counter write takes priority over an increment in the same cycle.
- R4: Control bits [15:8] hold a divider D. An enabled channel advances once every D+1 clock cycles, the first advance coming D+1 cycles after enabling. D=0 advances on every clock.
- R5: Status bit n is set on the clock edge where channel n advances away from a counter value equal to its compare value.
- R6: Status bits stay set whether or not the interrupt is enabled. Writing 1 to status bit n clears it, writing 0 leaves it unchanged, and a write of 0xFFFF clears all bits. A new match in the same cycle as a clear wins.
- R7: `irq[n]` equals status bit n ANDed with control bit 1 of channel n, and is updated on the same edge as those registers.
- R8: The counter wraps from 0xFFFFFFFF to 0 and keeps counting.
- R9: `rdata` presents the addressed register one cycle after a cycle with `rd_en` high, and is 0 after a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 2 | Per-channel interrupt request |

## Verification
A counter that advances one cycle early or late, or a prescaler that restarts at the wrong point, moves the cycle in which the status word reads back set. The bench samples the status word in the cycle just before the expected match and again just after it, so an off-by-one error shows on the very next read. A pending bit that is lost, or one that is cleared by a 0, shows as a wrong status read within a single access. A mismatch between the pending bit and the enable bit appears on `irq` one cycle after the control write.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned MAX_CH     = 6;
  localparam int unsigned STRIDE     = 4;
  localparam int unsigned CTRL_BASE  = 'h00;
  localparam int unsigned MATCH_BASE = 'h18;
  localparam int unsigned COUNT_BASE = 'h48;
  localparam int unsigned STAT_OFS   = 'h60;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned IE_BIT     = 1;
  localparam int unsigned DIV_LSB    = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_MATCH, SEL_COUNT, SEL_STAT
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e  kind;
    logic [2:0] idx;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned nch);
    reg_sel_t s;
    s.kind = SEL_NONE;
    s.idx  = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < nch) begin
        if (a == ADDR_W'(CTRL_BASE + STRIDE * i)) begin
          s.kind = SEL_CTRL;  s.idx = 3'(i);
        end
        if (a == ADDR_W'(MATCH_BASE + STRIDE * i)) begin
          s.kind = SEL_MATCH; s.idx = 3'(i);
        end
        if (a == ADDR_W'(COUNT_BASE + STRIDE * i)) begin
          s.kind = SEL_COUNT; s.idx = 3'(i);
        end
      end
    end
    if (a == ADDR_W'(STAT_OFS)) s.kind = SEL_STAT;
    return s;
  endfunction
endpackage

// File: rtl/tmt_prescaler.sv
module tmt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;

  assign tick = run && (pre_q >= div);

  always_ff @(posedge clk) begin
    if (rst || !run)  pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R4: with a nonzero divider two ticks are never adjacent
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic tick;

  tmt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .div (div),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (cnt_we)  cnt <= cnt_wdata;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  assign hit = tick && !cnt_we && (cnt == match);

  // R3: a stopped channel with no load keeps its value
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt));
  // R3: a load lands regardless of counting
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt == $past(cnt_wdata));
  // R8: all-ones steps to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/tmt_status.sv
module tmt_status #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] status_d,
  output logic [NCH-1:0] status_q
);
  assign status_d = (status_q & ~(clr_we ? clr_mask : '0)) | hit;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R6: pending bit survives anything but a 1 written to it
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
      (status_q[g] && !(clr_we && clr_mask[g])) |=> status_q[g]);
    // R5: a match always leaves the bit set
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> status_q[g]);
    // R5: the bit only rises from a match
    a_r5_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(status_q[g]) |-> $past(hit[g]));
  end
endmodule

// File: rtl/twin_match_timer.sv
module twin_match_timer #(
  parameter int NCH   = 2,
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [NCH-1:0] irq
);
  import tmt_pkg::*;

  reg_sel_t sel;
  assign sel = decode_addr(addr, NCH);

  logic [NCH-1:0]   en_q, ie_q, ie_d, hit, status_d, status_q;
  logic [DIV_W-1:0] div_q   [NCH];
  logic [CNT_W-1:0] match_q [NCH];
  logic [CNT_W-1:0] cnt     [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_ctrl, wr_match, wr_cnt;
    assign wr_ctrl  = wr_en && sel.kind == SEL_CTRL  && sel.idx == 3'(g);
    assign wr_match = wr_en && sel.kind == SEL_MATCH && sel.idx == 3'(g);
    assign wr_cnt   = wr_en && sel.kind == SEL_COUNT && sel.idx == 3'(g);
    assign ie_d[g]  = wr_ctrl ? wdata[IE_BIT] : ie_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]    <= 1'b0;
        ie_q[g]    <= 1'b0;
        div_q[g]   <= '0;
        match_q[g] <= '0;
      end else begin
        if (wr_ctrl) begin
          en_q[g]  <= wdata[EN_BIT];
          ie_q[g]  <= wdata[IE_BIT];
          div_q[g] <= wdata[DIV_LSB +: DIV_W];
        end
        if (wr_match) match_q[g] <= wdata[CNT_W-1:0];
      end
    end

    tmt_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .run      (en_q[g]),
      .div      (div_q[g]),
      .cnt_we   (wr_cnt),
      .cnt_wdata(wdata[CNT_W-1:0]),
      .match    (match_q[g]),
      .cnt      (cnt[g]),
      .hit      (hit[g])
    );

    // R7: a masked channel never drives its line
    a_r7_masked: assert property (@(posedge clk) disable iff (rst)
      !ie_q[g] |-> !irq[g]);
    // R7: an enabled, pending channel drives its line
    a_r7_raise: assert property (@(posedge clk) disable iff (rst)
      (ie_q[g] && status_q[g]) |-> irq[g]);
  end

  tmt_status #(.NCH(NCH)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .clr_we  (wr_en && sel.kind == SEL_STAT),
    .clr_mask(wdata[NCH-1:0]),
    .status_d(status_d),
    .status_q(status_q)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel.idx == 3'(i)) begin
        case (sel.kind)
          SEL_CTRL: begin
            rd_mux[EN_BIT]             = en_q[i];
            rd_mux[IE_BIT]             = ie_q[i];
            rd_mux[DIV_LSB +: DIV_W]   = div_q[i];
          end
          SEL_MATCH: rd_mux[CNT_W-1:0] = match_q[i];
          SEL_COUNT: rd_mux[CNT_W-1:0] = cnt[i];
          default: ;
        endcase
      end
    end
    if (sel.kind == SEL_STAT) rd_mux[NCH-1:0] = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= '0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
      irq   <= status_d & ie_d;
    end
  end

  // R2: unmapped offsets read as zero
  a_r2_unmapped: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel.kind == SEL_NONE) |=> rdata == '0);
  // R9: no strobe, no data
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);
endmodule

// File: tb/twin_match_timer_test.sv
`timescale 1ns/1ps
module twin_match_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  bit done = 0;

  twin_match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,  8'h48, 32'd5,      32'd0,      "R3"},
    '{OP_RD,  8'h48, 32'd0,      32'd5,      "R3"},
    '{OP_WR,  8'h18, 32'd10,     32'd0,      "R2"},
    '{OP_RD,  8'h18, 32'd0,      32'd10,     "R2"},
    '{OP_RD,  8'h60, 32'd0,      32'd0,      "R6"},
    '{OP_WR,  8'h00, 32'h3,      32'd0,      "R3"},
    '{OP_WT,  8'h00, 32'd10,     32'd0,      "R5"},
    '{OP_RD,  8'h60, 32'd0,      32'd1,      "R5"},
    '{OP_IRQ, 8'h00, 32'd0,      32'd1,      "R7"},
    '{OP_WR,  8'h00, 32'h0,      32'd0,      "R3"},
    '{OP_RD,  8'h48, 32'd0,      32'd17,     "R3"},
    '{OP_WT,  8'h00, 32'd3,      32'd0,      "R3"},
    '{OP_RD,  8'h48, 32'd0,      32'd17,     "R3"},
    '{OP_IRQ, 8'h00, 32'd0,      32'd0,      "R7"},
    '{OP_RD,  8'h60, 32'd0,      32'd1,      "R6"},
    '{OP_WR,  8'h60, 32'h2,      32'd0,      "R6"},
    '{OP_RD,  8'h60, 32'd0,      32'd1,      "R6"},
    '{OP_WR,  8'h60, 32'h1,      32'd0,      "R6"},
    '{OP_RD,  8'h60, 32'd0,      32'd0,      "R6"},
    '{OP_WR,  8'h4C, 32'd0,      32'd0,      "R4"},
    '{OP_WR,  8'h1C, 32'd2,      32'd0,      "R4"},
    '{OP_WR,  8'h04, 32'h201,    32'd0,      "R4"},
    '{OP_WT,  8'h00, 32'd7,      32'd0,      "R4"},
    '{OP_RD,  8'h60, 32'd0,      32'd0,      "R4"},
    '{OP_WT,  8'h00, 32'd2,      32'd0,      "R4"},
    '{OP_RD,  8'h60, 32'd0,      32'd2,      "R4"},
    '{OP_IRQ, 8'h00, 32'd0,      32'd0,      "R7"},
    '{OP_WR,  8'h04, 32'h203,    32'd0,      "R7"},
    '{OP_IRQ, 8'h00, 32'd0,      32'd2,      "R7"},
    '{OP_RD,  8'h04, 32'd0,      32'h203,    "R2"},
    '{OP_WR,  8'h60, 32'hFFFF,   32'd0,      "R6"},
    '{OP_RD,  8'h60, 32'd0,      32'd0,      "R6"},
    '{OP_IRQ, 8'h00, 32'd0,      32'd0,      "R6"},
    '{OP_RD,  8'h10, 32'd0,      32'd0,      "R2"},
    '{OP_WR,  8'h30, 32'hDEADBEEF, 32'd0,    "R2"},
    '{OP_RD,  8'h30, 32'd0,      32'd0,      "R2"},
    '{OP_RD,  8'h18, 32'd0,      32'd10,     "R2"},
    '{OP_WR,  8'h04, 32'h0,      32'd0,      "R4"}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input logic [15:0] tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start just after a falling edge and end on one
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input logic [15:0] tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(rdata, 32'd0, "R1");
    check({30'd0, irq}, 32'd0, "R1");
    do_rd(8'h00, 32'd0, "R1");
    do_rd(8'h4C, 32'd0, "R1");
    do_rd(8'h60, 32'd0, "R1");

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:  do_wr(VECS[i].a, VECS[i].d);
        OP_RD:  do_rd(VECS[i].a, VECS[i].exp, VECS[i].tag);
        OP_WT:  repeat (VECS[i].d) @(negedge clk);
        default: check({30'd0, irq}, VECS[i].exp, VECS[i].tag);
      endcase
    end

    // R9: with no read strobe the data bus returns to zero
    @(negedge clk);
    check(rdata, 32'd0, "R9");

    // R8: wrap through all-ones without a spurious match at compare 0
    do_wr(8'h48, 32'hFFFF_FFFE);
    do_wr(8'h18, 32'd0);
    do_wr(8'h00, 32'h1);
    @(negedge clk);
    do_wr(8'h00, 32'h0);
    do_rd(8'h48, 32'd0, "R8");
    do_rd(8'h60, 32'd0, "R8");
    // R5: stepping away from 0 now matches
    do_wr(8'h00, 32'h1);
    repeat (2) @(negedge clk);
    do_rd(8'h60, 32'd1, "R5");
    // R3: load while counting wins over increment
    do_wr(8'h48, 32'd100);
    do_wr(8'h00, 32'h0);
    do_rd(8'h48, 32'd101, "R3");

    // R1: reset in the middle of activity
    do_wr(8'h04, 32'h3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({30'd0, irq}, 32'd0, "R1");
    do_rd(8'h60, 32'd0, "R1");
    do_rd(8'h48, 32'd0, "R1");
    do_rd(8'h04, 32'd0, "R1");

    finish_run();
  end
endmodule